// File: doc/BRIEF.md
# Adaptive Proportion Entropy Health Monitor

This block watches a one-bit stream of raw entropy samples and flags a large loss of entropy. It works in repeating test cycles. The first accepted sample of a cycle is kept as the reference bit. The block then counts how many samples in the next window match that reference. When the window closes, the block publishes the final match count with a one-cycle done pulse. If the count is greater than the cutoff, it sets an alarm that stays set until it is cleared.

A compile-time parameter picks one of two window/cutoff pairs. Samples are taken only on cycles where the valid input is high, so the source may deliver bits at any rate. A clear input drops the alarm and discards the test cycle in progress. The next accepted sample after a clear becomes a fresh reference. A new test cycle starts on the first accepted sample after a window closes, with no gap needed.

Top module: `apt_monitor`

## Requirements
- R1: After synchronous reset, the alarm, the done pulse and the published count are all zero.
- R2: The first accepted sample of each test cycle is stored as the reference and is not counted. A test cycle begins after reset, after a clear, and right after each window closes.
- R3: The window is the WIN accepted samples that follow the reference. In the clock cycle after the last of them is accepted, the done output is high and the published count equals the number of those samples that equal the reference (0 to WIN).
- R4: The alarm is set at the close of a window only when the count is strictly greater than the cutoff. A count equal to the cutoff does not set it.
- R5: Once set, the alarm stays high across later windows of any count until a clear arrives.
- R6: A clear drives the alarm low on the next cycle and restarts at a new reference. A sample presented in the same cycle as the clear is discarded.
- R7: Cycles with valid low have no effect on the reference, the count, the done pulse or the published count, whatever the sample bit holds.
- R8: Setting value 0 selects a window of 64 with a cutoff of 55. Setting value 1 selects a window of 4096 with a cutoff of 2240.
- R9: Done is high for exactly one cycle per window. The published count holds its value until the next window closes or a clear arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| samp_bit | input | 1 | Entropy sample |
| samp_vld | input | 1 | Sample is accepted on this cycle when high |
| alarm_clr | input | 1 | Clears the alarm and restarts the test cycle |
| alarm | output | 1 | Sticky entropy-loss alarm |
| win_done | output | 1 | One-cycle pulse when a window closes |
| last_cnt | output | $clog2(WIN+1) | Match count of the most recent window |

## Verification
The bench sweeps every possible match count, from 0 to 64, in the short setting, and uses both reference values. This exposes an off-by-one in the window length or a reference that gets counted, since either one shifts every published count by one. In both settings, the count equal to the cutoff and the count one above it are run. A design using greater-or-equal would alarm one count too early. Idle cycles carrying garbage bits are scattered through windows, and a sample is presented during a clear. A design that counted invalid cycles, or that took the clear-cycle sample as its reference, would report the wrong count. A low-count window that follows an alarming one checks that the alarm is not re-evaluated on every window.

// File: rtl/apt_pkg.sv
package apt_pkg;

    typedef enum logic {
        APT_SET_SHORT = 1'b0,
        APT_SET_LONG  = 1'b1
    } apt_set_e;

    typedef enum logic {
        PH_REF  = 1'b0,
        PH_SCAN = 1'b1
    } apt_phase_e;

    typedef struct packed {
        logic take;
        logic match;
        logic last;
    } apt_step_t;

    function automatic int unsigned apt_win(apt_set_e s);
        return (s == APT_SET_LONG) ? 4096 : 64;
    endfunction

    function automatic int unsigned apt_cut(apt_set_e s);
        return (s == APT_SET_LONG) ? 2240 : 55;
    endfunction

endpackage

// File: rtl/apt_ref_ctrl.sv
module apt_ref_ctrl
    import apt_pkg::*;
#(
    parameter int unsigned WIN   = 64,
    parameter int unsigned IDX_W = $clog2(WIN)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      vld,
    input  logic      smp,
    output apt_step_t step
);
    apt_phase_e       phase;
    logic             ref_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        step.take  = vld && !clr && (phase == PH_SCAN);
        step.match = step.take && (smp == ref_q);
        step.last  = step.take && (idx == IDX_W'(WIN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= PH_REF;
            ref_q <= 1'b0;
            idx   <= '0;
        end else if (vld) begin
            if (phase == PH_REF) begin
                ref_q <= smp;
                idx   <= '0;
                phase <= PH_SCAN;
            end else if (step.last) begin
                idx   <= '0;
                phase <= PH_REF;
            end else begin
                idx   <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/apt_match_counter.sv
module apt_match_counter
    import apt_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  apt_step_t        step,
    output logic [CNT_W-1:0] tally_next
);
    logic [CNT_W-1:0] tally_q;

    assign tally_next = tally_q + {{(CNT_W-1){1'b0}}, step.match};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tally_q <= '0;
        end else if (step.take) begin
            tally_q <= step.last ? '0 : tally_next;
        end
    end
endmodule

// File: rtl/apt_verdict.sv
module apt_verdict
    import apt_pkg::*;
#(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned CUT   = 55
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  apt_step_t        step,
    input  logic [CNT_W-1:0] tally_next,
    output logic             alarm,
    output logic             done,
    output logic [CNT_W-1:0] last_cnt
);
    logic over;
    assign over = tally_next > CNT_W'(CUT);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            alarm    <= 1'b0;
            done     <= 1'b0;
            last_cnt <= '0;
        end else begin
            done <= step.last;
            if (step.last) begin
                last_cnt <= tally_next;
                if (over) alarm <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/apt_monitor.sv
module apt_monitor
    import apt_pkg::*;
#(
    parameter apt_set_e    SETTING = APT_SET_SHORT,
    parameter int unsigned WIN     = apt_win(SETTING),
    parameter int unsigned CUT     = apt_cut(SETTING),
    parameter int unsigned CNT_W   = $clog2(WIN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             samp_bit,
    input  logic             samp_vld,
    input  logic             alarm_clr,
    output logic             alarm,
    output logic             win_done,
    output logic [CNT_W-1:0] last_cnt
);
    localparam int unsigned IDX_W = $clog2(WIN);

    apt_step_t        step;
    logic [CNT_W-1:0] tally_next;

    apt_ref_ctrl #(.WIN(WIN), .IDX_W(IDX_W)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .clr (alarm_clr),
        .vld (samp_vld),
        .smp (samp_bit),
        .step(step)
    );

    apt_match_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (alarm_clr),
        .step      (step),
        .tally_next(tally_next)
    );

    apt_verdict #(.CNT_W(CNT_W), .CUT(CUT)) u_verdict (
        .clk       (clk),
        .rst       (rst),
        .clr       (alarm_clr),
        .step      (step),
        .tally_next(tally_next),
        .alarm     (alarm),
        .done      (win_done),
        .last_cnt  (last_cnt)
    );
endmodule

// File: rtl/apt_monitor_chk.sv
module apt_monitor_chk #(
    parameter int unsigned WIN   = 64,
    parameter int unsigned CUT   = 55,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             samp_vld,
    input logic             alarm_clr,
    input logic             alarm,
    input logic             win_done,
    input logic [CNT_W-1:0] last_cnt
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        win_done |=> !win_done);

    p_alarm_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (alarm && !alarm_clr) |=> alarm);

    p_alarm_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> (win_done && (last_cnt > CNT_W'(CUT))));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        alarm_clr |=> (!alarm && !win_done));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        win_done |-> (last_cnt <= CNT_W'(WIN)));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!samp_vld && !alarm_clr) |=> (!win_done && $stable(last_cnt)));
endmodule

bind apt_monitor apt_monitor_chk #(.WIN(WIN), .CUT(CUT), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .samp_vld (samp_vld),
    .alarm_clr(alarm_clr),
    .alarm    (alarm),
    .win_done (win_done),
    .last_cnt (last_cnt)
);

// File: tb/apt_monitor_bench.sv
module apt_monitor_bench;
    import apt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        s_bit = 1'b0, s_vld = 1'b0, s_clr = 1'b0;
    logic        s_alarm, s_done;
    logic [6:0]  s_cnt;
    logic        l_bit = 1'b0, l_vld = 1'b0, l_clr = 1'b0;
    logic        l_alarm, l_done;
    logic [12:0] l_cnt;

    apt_monitor #(.SETTING(APT_SET_SHORT)) u_apt_monitor (
        .clk(clk), .rst(rst), .samp_bit(s_bit), .samp_vld(s_vld),
        .alarm_clr(s_clr), .alarm(s_alarm), .win_done(s_done), .last_cnt(s_cnt)
    );

    apt_monitor #(.SETTING(APT_SET_LONG)) u_apt_monitor_long (
        .clk(clk), .rst(rst), .samp_bit(l_bit), .samp_vld(l_vld),
        .alarm_clr(l_clr), .alarm(l_alarm), .win_done(l_done), .last_cnt(l_cnt)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic drive(input bit lng, input logic v, input logic b, input logic c);
        @(negedge clk);
        if (lng) begin l_vld = v; l_bit = b; l_clr = c; end
        else     begin s_vld = v; s_bit = b; s_clr = c; end
    endtask

    function automatic int o_alarm(input bit lng);
        return lng ? int'(l_alarm) : int'(s_alarm);
    endfunction
    function automatic int o_done(input bit lng);
        return lng ? int'(l_done) : int'(s_done);
    endfunction
    function automatic int o_cnt(input bit lng);
        return lng ? int'(l_cnt) : int'(s_cnt);
    endfunction

    // reference, then win samples: first k equal to the reference
    task automatic window(input bit lng, input logic rb, input int win, input int k, input bit gaps);
        drive(lng, 1'b1, rb, 1'b0);
        for (int i = 0; i < win; i++) begin
            if (gaps && (i % 5 == 2)) drive(lng, 1'b0, rb ^ i[0], 1'b0);
            drive(lng, 1'b1, (i < k) ? rb : ~rb, 1'b0);
        end
        drive(lng, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic clear(input bit lng);
        drive(lng, 1'b1, 1'b1, 1'b1);  // sample in the clear cycle must be dropped (R6)
        drive(lng, 1'b0, 1'b0, 1'b0);
        chk("R6 alarm low after clear", o_alarm(lng), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 short alarm", o_alarm(0), 0);
        chk("R1 short done", o_done(0), 0);
        chk("R1 short count", o_cnt(0), 0);
        chk("R1 long alarm", o_alarm(1), 0);
        chk("R1 long count", o_cnt(1), 0);

        // R2 R3 R4 R8: every count in the short setting
        for (int k = 0; k <= 64; k++) begin
            clear(0);
            window(0, k[0], 64, k, (k % 3) == 0);
            chk($sformatf("R3 done k=%0d", k), o_done(0), 1);
            chk($sformatf("R3 R2 count k=%0d", k), o_cnt(0), k);
            chk($sformatf("R4 R8 alarm k=%0d", k), o_alarm(0), (k > 55) ? 1 : 0);
            drive(0, 1'b0, 1'b1, 1'b0);
            chk($sformatf("R9 pulse k=%0d", k), o_done(0), 0);
            chk($sformatf("R9 hold k=%0d", k), o_cnt(0), k);
        end

        // R5: low window after an alarm keeps alarm
        clear(0);
        window(0, 1'b0, 64, 60, 1'b0);
        chk("R5 alarm set", o_alarm(0), 1);
        window(0, 1'b1, 64, 10, 1'b1);
        chk("R5 count", o_cnt(0), 10);
        chk("R5 sticky", o_alarm(0), 1);

        // R7: invalid cycles with toggling bits change nothing
        for (int i = 0; i < 20; i++) drive(0, 1'b0, i[0], 1'b0);
        chk("R7 no done", o_done(0), 0);
        chk("R7 count held", o_cnt(0), 10);
        chk("R7 alarm held", o_alarm(0), 1);

        // R6: clear mid-window, clear-cycle sample (1) ignored, new ref 0
        drive(0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) drive(0, 1'b1, 1'b0, 1'b0);
        clear(0);
        chk("R6 count reset", o_cnt(0), 0);
        window(0, 1'b0, 64, 64, 1'b0);
        chk("R6 R2 fresh reference count", o_cnt(0), 64);
        chk("R6 alarm after fresh window", o_alarm(0), 1);

        // R2 back to back windows: reference right after done
        clear(0);
        drive(0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 64; i++) drive(0, 1'b1, (i < 7) ? 1'b1 : 1'b0, 1'b0);
        drive(0, 1'b1, 1'b0, 1'b0);  // next reference, same cycle done is visible
        chk("R3 b2b first done", o_done(0), 1);
        chk("R3 b2b first count", o_cnt(0), 7);
        for (int i = 0; i < 64; i++) drive(0, 1'b1, (i < 33) ? 1'b0 : 1'b1, 1'b0);
        drive(0, 1'b0, 1'b0, 1'b0);
        chk("R2 b2b second count", o_cnt(0), 33);

        // R8 R4: long setting at cutoff and one above
        window(1, 1'b1, 4096, 2240, 1'b0);
        chk("R8 long done", o_done(1), 1);
        chk("R8 long count at cutoff", o_cnt(1), 2240);
        chk("R4 long no alarm at cutoff", o_alarm(1), 0);
        clear(1);
        window(1, 1'b0, 4096, 2241, 1'b1);
        chk("R8 long count above cutoff", o_cnt(1), 2241);
        chk("R4 long alarm above cutoff", o_alarm(1), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule